// File: doc/BRIEF.md
# Programmable Interval Down-Counter Timer

This block is a 16-bit interval timer that counts down from a programmable reload value. It is controlled through a byte-wide register port addressed by a 4-bit register select. Software writes the reload value one byte at a time into a latch. Reads at the same two addresses return the live count. A control register starts and stops the timer and picks the count source. The source is either every system clock or rising edges on an external count pin, which is synchronised to the clock inside the block. A self-clearing bit in the control register copies the latch into the counter.

When a count event arrives while the counter holds zero, the counter reloads from the latch and an underflow is signalled. Each underflow sets a status flag. The flag can raise an interrupt through a write-only mask. It can also drive bit 6 of a neighbouring port, either as a pulse that lasts one count period or as a level that toggles on each underflow. While the port drive is enabled, the output-enable signal tells the port to use the timer level in place of its own direction and data settings for that bit.

Top module: `ivl_timer`

## Requirements
- R1: After reset the counter, reload latch and control register are 0. Reads at 0x04, 0x05, 0x0D, 0x0E and 0x01 return 0x00, and `pb6_out`, `pb6_oe` and `irq` are low.
- R2: A write at 0x04 sets the latch low byte and a write at 0x05 sets the latch high byte. Neither write changes the counter. Reads at 0x04 and 0x05 return the counter low and high bytes.
- R3: Control register 0x0E has these bits: bit 0 run, bit 1 port drive enable, bit 2 toggle mode (1) or pulse mode (0), and bit 5 external count source. Bit 4 is a strobe that copies the latch into the counter on the write and reads back as 0. Bits 3, 6 and 7 read as 0.
- R4: With run set and bit 5 clear, the counter decrements by one on every clock. With run clear, it holds its value.
- R5: A count event while the counter is 0 reloads it from the latch and produces an underflow, so a latch value L gives the sequence L, L-1, …, 0, L.
- R6: With bit 5 set, the counter decrements once for each rising edge of `cnt_pin`. The change is visible after the third rising clock edge counted from the clock edge that first samples the pin high. Clocks without an edge leave the counter unchanged, and a pin held high counts only once.
- R7: An underflow sets bit 0 of the status register at 0x0D. A read of 0x0D with `rd_en` high clears the flag, unless an underflow occurs in the same cycle.
- R8: A write to 0x0D sets the write-only timer mask bit when data bit 7 is 1 and data bit 0 is 1. It clears the mask bit when bit 7 is 0 and bit 0 is 1. Bit 7 of 0x0D and the `irq` output are high exactly when the flag and the mask bit are both set.
- R9: In pulse mode the port level goes high on the cycle of an underflow. It stays high until the next count event that is not itself an underflow.
- R10: In toggle mode the port level inverts on each underflow and holds between underflows. Any control register write resets the toggle level to 0.
- R11: `pb6_oe` equals control bit 1. When it is 1, `pb6_out` and bit 6 of a read at 0x01 carry the timer port level. When it is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 4 | Register select address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the read-clear of 0x0D) |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, combinational from `reg_sel` |
| cnt_pin | input | 1 | External count input, asynchronous |
| pb6_out | output | 1 | Timer level for port bit 6 |
| pb6_oe | output | 1 | Timer owns port bit 6 |
| irq | output | 1 | Masked interrupt request |

## Verification
A register write takes effect at the clock edge on which it is held, so its result can be read one cycle later. In system-clock mode the counter moves on every edge, and an underflow, the flag, the pulse level and the toggle level all change on the same edge as the reload. An external count pulse only reaches the counter on the third clock edge, because of the two synchroniser stages and the edge detector. Every bench task therefore drives inputs on a falling edge and samples 1 ns after a falling edge. The pin-pulse task waits three falling edges before it returns, so each check lands after the cycle in which its result is due.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Register select addresses (fixed by the register map).
    localparam logic [3:0] A_PORTB = 4'h1;
    localparam logic [3:0] A_LATLO = 4'h4;
    localparam logic [3:0] A_ISR   = 4'hD;
    localparam logic [3:0] A_CTRL  = 4'hE;

    // Bit positions.
    localparam int unsigned FORCE_BIT   = 4;
    localparam int unsigned MASK_SETCLR = 7;
    localparam int unsigned MASK_SRC    = 0;
    localparam int unsigned PORT_BIT    = 6;

    typedef struct packed {
        logic ext_src;
        logic toggle;
        logic port_en;
        logic run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] d);
        ctrl_t c;
        c.run     = d[0];
        c.port_en = d[1];
        c.toggle  = d[2];
        c.ext_src = d[5];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        return {2'b00, c.ext_src, 2'b00, c.toggle, c.port_en, c.run};
    endfunction

    function automatic logic [7:0] status_byte(input logic sum, input logic flag);
        return {sum, 6'b0, flag};
    endfunction

endpackage

// File: rtl/ivt_cnt_sync.sv
module ivt_cnt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[s] <= 1'b0;
                    else     sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int unsigned W  = 16,
    parameter int unsigned NB = W / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] lat_wr,
    input  logic [7:0]    wr_byte,
    input  logic          force_ld,
    input  logic          cnt_ev,
    output logic [W-1:0]  count_o,
    output logic [W-1:0]  latch_o,
    output logic          uf_o
);
    logic [7:0]   lat_b [NB];
    logic [W-1:0] count_q;

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_lat
            always_ff @(posedge clk) begin
                if (rst)            lat_b[b] <= 8'h00;
                else if (lat_wr[b]) lat_b[b] <= wr_byte;
            end
            assign latch_o[b*8 +: 8] = lat_b[b];
        end
    endgenerate

    assign uf_o = cnt_ev && !force_ld && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst)           count_q <= '0;
        else if (force_ld) count_q <= latch_o;
        else if (uf_o)     count_q <= latch_o;
        else if (cnt_ev)   count_q <= count_q - 1'b1;
    end

    assign count_o = count_q;
endmodule

// File: rtl/ivt_port_out.sv
module ivt_port_out (
    input  logic clk,
    input  logic rst,
    input  logic uf_i,
    input  logic cnt_ev_i,
    input  logic ctrl_wr_i,
    input  logic toggle_i,
    output logic pulse_o,
    output logic tog_o,
    output logic level_o
);
    logic pulse_q, tog_q;

    always_ff @(posedge clk) begin
        if (rst)           pulse_q <= 1'b0;
        else if (uf_i)     pulse_q <= 1'b1;
        else if (cnt_ev_i) pulse_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)            tog_q <= 1'b0;
        else if (ctrl_wr_i) tog_q <= 1'b0;
        else if (uf_i)      tog_q <= ~tog_q;
    end

    assign pulse_o = pulse_q;
    assign tog_o   = tog_q;
    assign level_o = toggle_i ? tog_q : pulse_q;
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
    input  logic clk,
    input  logic rst,
    input  logic uf_i,
    input  logic clr_i,
    input  logic mask_wr_i,
    input  logic mask_set_i,
    input  logic mask_src_i,
    output logic flag_o,
    output logic mask_o,
    output logic irq_o
);
    logic flag_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (uf_i)  flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= 1'b0;
        else if (mask_wr_i && mask_src_i) mask_q <= mask_set_i;
    end

    assign flag_o = flag_q;
    assign mask_o = mask_q;
    assign irq_o  = flag_q & mask_q;
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] reg_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cnt_pin,
    output logic       pb6_out,
    output logic       pb6_oe,
    output logic       irq
);
    localparam int unsigned NB = CNT_W / 8;

    ctrl_t            ctrl_q;
    logic             ctrl_wr, force_ld, pin_rise, cnt_ev, uf;
    logic [NB-1:0]    lat_wr;
    logic [CNT_W-1:0] count, latch;
    logic             pulse_lvl, tog_lvl, port_lvl;
    logic             flag, mask, isr_wr, isr_clr;

    assign ctrl_wr  = wr_en && (reg_sel == A_CTRL);
    assign force_ld = ctrl_wr && wr_data[FORCE_BIT];
    assign isr_wr   = wr_en && (reg_sel == A_ISR);
    assign isr_clr  = rd_en && (reg_sel == A_ISR);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_from_byte(wr_data);
    end

    always_comb begin
        for (int b = 0; b < NB; b++)
            lat_wr[b] = wr_en && (reg_sel == A_LATLO + 4'(b));
    end

    ivt_cnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(cnt_pin), .rise_o(pin_rise)
    );

    assign cnt_ev = ctrl_q.run && (ctrl_q.ext_src ? pin_rise : 1'b1);

    ivt_counter #(.W(CNT_W), .NB(NB)) u_cnt (
        .clk(clk), .rst(rst), .lat_wr(lat_wr), .wr_byte(wr_data),
        .force_ld(force_ld), .cnt_ev(cnt_ev),
        .count_o(count), .latch_o(latch), .uf_o(uf)
    );

    ivt_port_out u_port (
        .clk(clk), .rst(rst), .uf_i(uf), .cnt_ev_i(cnt_ev),
        .ctrl_wr_i(ctrl_wr), .toggle_i(ctrl_q.toggle),
        .pulse_o(pulse_lvl), .tog_o(tog_lvl), .level_o(port_lvl)
    );

    ivt_irq u_irq (
        .clk(clk), .rst(rst), .uf_i(uf), .clr_i(isr_clr),
        .mask_wr_i(isr_wr), .mask_set_i(wr_data[MASK_SETCLR]),
        .mask_src_i(wr_data[MASK_SRC]),
        .flag_o(flag), .mask_o(mask), .irq_o(irq)
    );

    assign pb6_oe  = ctrl_q.port_en;
    assign pb6_out = ctrl_q.port_en & port_lvl;

    always_comb begin
        rd_data = 8'h00;
        case (reg_sel)
            A_PORTB: rd_data[PORT_BIT] = pb6_out;
            A_ISR:   rd_data = status_byte(irq, flag);
            A_CTRL:  rd_data = ctrl_to_byte(ctrl_q);
            default: ;
        endcase
        for (int b = 0; b < NB; b++)
            if (reg_sel == A_LATLO + 4'(b)) rd_data = count[b*8 +: 8];
    end
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_ev,
    input logic         force_ld,
    input logic         uf,
    input logic [W-1:0] count,
    input logic [W-1:0] latch,
    input logic         ctrl_wr,
    input logic         pulse_lvl,
    input logic         tog_lvl,
    input logic         flag,
    input logic         irq
);
    // R4: a count event on a nonzero counter steps it down by one
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_ev && !force_ld && count != '0) |=> count == $past(count) - 1'b1);

    // R5: a count event at zero reloads from the latch
    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_ev && !force_ld && count == '0) |=> count == $past(latch));

    // R6: no count event and no strobe leaves the counter alone
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cnt_ev && !force_ld) |=> count == $past(count));

    // R3: the force strobe copies the latch
    p_force_r3: assert property (@(posedge clk) disable iff (rst)
        force_ld |=> count == $past(latch));

    // R7: underflow sets the flag
    p_flag_r7: assert property (@(posedge clk) disable iff (rst)
        uf |=> flag);

    // R8: no interrupt without a pending flag
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    // R9: pulse level rises on underflow and falls on the next plain event
    p_pulse_set_r9: assert property (@(posedge clk) disable iff (rst)
        uf |=> pulse_lvl);
    p_pulse_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_ev && !uf) |=> !pulse_lvl);

    // R10: toggle level flips only on underflow
    p_tog_flip_r10: assert property (@(posedge clk) disable iff (rst)
        (uf && !ctrl_wr) |=> tog_lvl != $past(tog_lvl));
    p_tog_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!uf && !ctrl_wr) |=> tog_lvl == $past(tog_lvl));
endmodule

bind ivl_timer ivt_checker #(.W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cnt_ev(cnt_ev), .force_ld(force_ld), .uf(uf),
    .count(count), .latch(latch), .ctrl_wr(ctrl_wr),
    .pulse_lvl(pulse_lvl), .tog_lvl(tog_lvl), .flag(flag), .irq(irq)
);

// File: tb/ivl_timer_bench.sv
module ivl_timer_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] reg_sel;
    logic       wr_en, rd_en;
    logic [7:0] wr_data, rd_data;
    logic       cnt_pin, pb6_out, pb6_oe, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ivl_timer u_ivl_timer (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .cnt_pin(cnt_pin),
        .pb6_out(pb6_out), .pb6_oe(pb6_oe), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_sel = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_sel = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, int'(v), int'(exp));
    endtask

    task automatic pin_pulse();
        cnt_pin = 1'b1;
        @(negedge clk);
        cnt_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 counter lo", 4'h4, 8'h00);
        rd_chk("R1 counter hi", 4'h5, 8'h00);
        rd_chk("R1 status", 4'hD, 8'h00);
        rd_chk("R1 control", 4'hE, 8'h00);
        rd_chk("R1 port", 4'h1, 8'h00);
        check("R1 pb6_out", int'(pb6_out), 0);
        check("R1 pb6_oe", int'(pb6_oe), 0);
        check("R1 irq", int'(irq), 0);
    endtask

    task automatic t_regs();
        wr(4'h4, 8'h34);
        wr(4'h5, 8'h12);
        rd_chk("R2 latch write leaves counter", 4'h4, 8'h00);
        wr(4'hE, 8'h10);
        rd_chk("R3 strobe reads 0", 4'hE, 8'h00);
        rd_chk("R2 counter lo", 4'h4, 8'h34);
        rd_chk("R2 counter hi", 4'h5, 8'h12);
        wr(4'hE, 8'hC8);
        rd_chk("R3 reserved bits", 4'hE, 8'h00);
        wr(4'hE, 8'h26);
        rd_chk("R3 readback", 4'hE, 8'h26);
        check("R11 oe follows bit1", int'(pb6_oe), 1);
        rd_chk("R2 stopped counter holds", 4'h4, 8'h34);
        wr(4'hE, 8'h00);
    endtask

    task automatic t_sysclk();
        logic [7:0] a, b;
        wr(4'h4, 8'h03);
        wr(4'h5, 8'h00);
        wr(4'hE, 8'h13);
        reg_sel = 4'h4;
        for (int i = 0; i < 9; i++) begin
            #1;
            check("R4 R5 sysclk count", int'(rd_data), 3 - (i % 4));
            check("R9 sysclk pulse", int'(pb6_out), (i > 0 && i % 4 == 0) ? 1 : 0);
            @(negedge clk);
        end
        wr(4'hE, 8'h00);
        rd(4'h4, a);
        @(negedge clk); @(negedge clk);
        rd(4'h4, b);
        check("R4 stopped holds", int'(b), int'(a));
        rd_chk("R7 flag unmasked", 4'hD, 8'h01);
        check("R8 irq masked off", int'(irq), 0);
        rd_chk("R7 read clears", 4'hD, 8'h00);
    endtask

    task automatic t_ext();
        wr(4'hD, 8'h81);
        wr(4'h4, 8'h08);
        wr(4'h5, 8'h00);
        wr(4'hE, 8'h33);
        rd_chk("R3 force to 8", 4'h4, 8'h08);
        repeat (4) @(negedge clk);
        rd_chk("R6 idle clocks", 4'h4, 8'h08);
        cnt_pin = 1'b1;
        repeat (6) @(negedge clk);
        cnt_pin = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk("R6 held high counts once", 4'h4, 8'h07);
        repeat (7) pin_pulse();
        rd_chk("R6 reaches zero", 4'h4, 8'h00);
        check("R8 no irq yet", int'(irq), 0);
        pin_pulse();
        rd_chk("R5 reload", 4'h4, 8'h08);
        check("R9 pulse high", int'(pb6_out), 1);
        check("R8 irq", int'(irq), 1);
        rd_chk("R7 R8 status", 4'hD, 8'h81);
        rd_chk("R7 cleared", 4'hD, 8'h00);
        check("R8 irq cleared", int'(irq), 0);
        pin_pulse();
        rd_chk("R6 next count", 4'h4, 8'h07);
        check("R9 pulse ends", int'(pb6_out), 0);
    endtask

    task automatic t_toggle();
        wr(4'hE, 8'h37);
        check("R10 reset level", int'(pb6_out), 0);
        repeat (9) pin_pulse();
        rd_chk("R5 toggle reload", 4'h4, 8'h08);
        check("R10 first flip", int'(pb6_out), 1);
        rd_chk("R11 port read", 4'h1, 8'h40);
        pin_pulse();
        rd_chk("R6 count", 4'h4, 8'h07);
        check("R10 holds", int'(pb6_out), 1);
        repeat (8) pin_pulse();
        rd_chk("R5 second reload", 4'h4, 8'h08);
        check("R10 second flip", int'(pb6_out), 0);
        wr(4'hE, 8'h25);
        check("R11 oe off", int'(pb6_oe), 0);
        rd_chk("R11 port read off", 4'h1, 8'h00);
        wr(4'hD, 8'h01);
        repeat (9) pin_pulse();
        check("R8 masked irq", int'(irq), 0);
        check("R11 out gated", int'(pb6_out), 0);
        rd_chk("R8 flag only", 4'hD, 8'h01);
    endtask

    initial begin
        rst = 1'b1; reg_sel = '0; wr_en = 1'b0; rd_en = 1'b0;
        wr_data = '0; cnt_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_sysclk();
        t_ext();
        t_toggle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule